// File: doc/BRIEF.md
# Packed Decimal Adder-Subtractor

This block performs decimal-mode arithmetic on packed binary-coded-decimal bytes. Each byte holds one decimal digit per 4-bit nibble, with the least significant digit in bits 3:0. An accumulator value, an operand value and an incoming carry are combined in one of two ways. The first is an add with carry. The second is a subtract in which a clear carry means one is borrowed. The block returns a packed decimal result together with a carry out and three condition flags: negative, zero and overflow.

An arithmetic unit selects this block in place of its binary adder when the processor's decimal flag is set and an add or subtract is executed. Each digit is corrected on its own, modulo ten. An explicit carry or borrow passes to the next digit up. The flags are taken from the corrected decimal result, not from a binary sum. The number of digits is a parameter, and the default is two, which gives one byte.

The arithmetic is combinational. All outputs are registered once, so results appear one clock after the inputs are sampled. Inputs are assumed to be valid decimal digits (0 to 9 in every nibble).

Top module: `bcd_addsub`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output becomes 0 at that edge.
- R2: Outputs change only at a rising clock edge. They reflect the inputs sampled at the previous edge, so the latency is one cycle.
- R3: With `sub_i` = 0 (add), `res_o` is the decimal value of (acc + opnd + carry_i) modulo 100, packed with the units digit in bits 3:0 and the tens digit in bits 7:4.
- R4: With `sub_i` = 0, `carry_o` is 1 exactly when acc + opnd + carry_i is 100 or more.
- R5: With `sub_i` = 1 (subtract), `res_o` is the decimal value of (acc − opnd − (1 − carry_i)) modulo 100, in the same packed form.
- R6: With `sub_i` = 1, `carry_o` is 0 exactly when acc − opnd − (1 − carry_i) is negative, and 1 otherwise.
- R7: A units digit that reaches ten or more carries one into the tens digit. A units digit that goes below zero is corrected by ten and borrows one from the tens digit.
- R8: `neg_o` equals bit 7 of the corrected result `res_o`.
- R9: `zero_o` is 1 exactly when the corrected result is 0x00.
- R10: `ovf_o` is 1 exactly when bit 7 of acc equals bit 7 of opnd and bit 7 of the corrected result differs from them. The same rule applies to both operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Accumulator, packed decimal |
| opnd_i | input | 8 | Operand, packed decimal |
| carry_i | input | 1 | Incoming carry (a clear carry means borrow when subtracting) |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| res_o | output | 8 | Packed decimal result (registered) |
| carry_o | output | 1 | Carry out, or not-borrow when subtracting (registered) |
| neg_o | output | 1 | Bit 7 of the result (registered) |
| zero_o | output | 1 | Result is zero (registered) |
| ovf_o | output | 1 | Sign-style overflow flag (registered) |

## Verification
On every cycle the assertions check the following:
- every result nibble stays a legal decimal digit;
- the negative and zero flags agree with the registered result;
- overflow stays clear whenever the two input sign bits differed;
- reset clears all outputs;
- the identities "add zero without carry returns the accumulator" and "subtracting a value from itself with carry set gives zero and no borrow" hold.

Only the bench's sweeps can show that the sums and differences are numerically right. The bench covers every pair of decimal bytes under both operations and both carry values. It also shows where the carry and borrow boundaries between digits fall, and the one-cycle latency.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned RADIX = 10;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_pkg::*;
(
  input  logic [NIB_W-1:0] a_i,
  input  logic [NIB_W-1:0] m_i,
  input  logic             ci_i,
  input  bcd_op_e          op_i,
  output logic [NIB_W-1:0] d_o,
  output logic             co_o
);
  localparam int unsigned TW = NIB_W + 2;
  localparam logic signed [TW-1:0] TEN = TW'(RADIX);

  logic signed [TW-1:0] sa, sm, sc, sb, sum, dif, adj;

  always_comb begin
    sa  = signed'({2'b00, a_i});
    sm  = signed'({2'b00, m_i});
    sc  = signed'({{(TW-1){1'b0}}, ci_i});
    sb  = signed'({{(TW-1){1'b0}}, ~ci_i});
    sum = sa + sm + sc;
    dif = sa - sm - sb;
    if (op_i == OP_ADD) begin
      if (sum >= TEN) begin
        adj  = sum - TEN;
        co_o = 1'b1;
      end else begin
        adj  = sum;
        co_o = 1'b0;
      end
    end else begin
      if (dif < 0) begin
        adj  = dif + TEN;
        co_o = 1'b0;
      end else begin
        adj  = dif;
        co_o = 1'b1;
      end
    end
    d_o = adj[NIB_W-1:0];
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen #(
  parameter int unsigned W = 8
) (
  input  logic         a_msb_i,
  input  logic         m_msb_i,
  input  logic [W-1:0] res_i,
  output logic         neg_o,
  output logic         zero_o,
  output logic         ovf_o
);
  always_comb begin
    neg_o  = res_i[W-1];
    zero_o = (res_i == '0);
    ovf_o  = (a_msb_i == m_msb_i) && (res_i[W-1] != a_msb_i);
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W   = NDIG * NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         neg_o,
  output logic         zero_o,
  output logic         ovf_o
);
  bcd_op_e        op;
  logic [NDIG:0]  chain;
  logic [W-1:0]   res_c;
  logic           n_c, z_c, v_c;

  assign op       = sub_i ? OP_SUB : OP_ADD;
  assign chain[0] = carry_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit_cell u_cell (
      .a_i  (acc_i [g*NIB_W +: NIB_W]),
      .m_i  (opnd_i[g*NIB_W +: NIB_W]),
      .ci_i (chain[g]),
      .op_i (op),
      .d_o  (res_c[g*NIB_W +: NIB_W]),
      .co_o (chain[g+1])
    );
  end

  bcd_flag_gen #(.W(W)) u_flags (
    .a_msb_i (acc_i[W-1]),
    .m_msb_i (opnd_i[W-1]),
    .res_i   (res_c),
    .neg_o   (n_c),
    .zero_o  (z_c),
    .ovf_o   (v_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      res_o   <= res_c;
      carry_o <= chain[NDIG];
      neg_o   <= n_c;
      zero_o  <= z_c;
      ovf_o   <= v_c;
    end
  end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W   = NDIG * 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         carry_i,
  input logic         sub_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         neg_o,
  input logic         zero_o,
  input logic         ovf_o
);
  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++)
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && !carry_o && !neg_o && !zero_o && !ovf_o));

  // R3
  digit_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && digits_ok($past(acc_i)) && digits_ok($past(opnd_i))) |-> digits_ok(res_o));

  // R3
  add_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sub_i) && !$past(carry_i) && $past(opnd_i) == '0
     && digits_ok($past(acc_i))) |-> (res_o == $past(acc_i) && !carry_o));

  // R6
  sub_self_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sub_i) && $past(carry_i) && $past(acc_i) == $past(opnd_i)
     && digits_ok($past(acc_i))) |-> (res_o == '0 && carry_o && zero_o));

  // R8
  neg_bit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (neg_o == res_o[W-1]));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (zero_o == (res_o == '0)));

  // R10
  ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(acc_i[W-1]) != $past(opnd_i[W-1]))) |-> !ovf_o);
endmodule

bind bcd_addsub bcd_addsub_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/test_bcd_addsub.sv
`timescale 1ns/1ps
module test_bcd_addsub;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] acc, opnd, res;
  logic       cin, sub, cout, neg, zero, ovf;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_addsub i_bcd_addsub (
    .clk(clk), .rst(rst), .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .sub_i(sub),
    .res_o(res), .carry_o(cout), .neg_o(neg), .zero_o(zero), .ovf_o(ovf)
  );

  function automatic int to_dec(input logic [7:0] b);
    return 10 * int'(b[7:4]) + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return {4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] m, input logic c, input logic s);
    @(negedge clk);
    acc = a; opnd = m; cin = c; sub = s;
    @(negedge clk);
  endtask

  task automatic check_vec(input int ai, input int mi, input int c, input int s);
    int         t, r;
    bit         ec;
    logic [7:0] eres;
    if (s == 0) begin
      t  = ai + mi + c;
      ec = (t >= 100);
      r  = t % 100;
    end else begin
      t  = ai - mi - (1 - c);
      ec = (t >= 0);
      r  = (t + 100) % 100;
    end
    eres = to_bcd(r);
    if (s == 0) begin
      chk(res == eres, "R3", res, eres);
      chk(cout == ec, "R4", cout, ec);
    end else begin
      chk(res == eres, "R5", res, eres);
      chk(cout == ec, "R6", cout, ec);
    end
    chk(neg == eres[7], "R8", neg, eres[7]);
    chk(zero == (eres == 8'h00), "R9", zero, eres == 8'h00);
    chk(ovf == ((acc[7] == opnd[7]) && (eres[7] != acc[7])), "R10", ovf,
        (acc[7] == opnd[7]) && (eres[7] != acc[7]));
  endtask

  initial begin
    rst = 1'b1; acc = 8'h99; opnd = 8'h99; cin = 1'b1; sub = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(res == 8'h00 && !cout && !neg && !zero && !ovf, "R1", {res, cout, neg, zero, ovf}, 0);
    rst = 1'b0;

    // R7: carry from units into tens, and borrow from tens
    apply(8'h19, 8'h01, 1'b0, 1'b0);
    chk(res == 8'h20 && !cout, "R7", res, 8'h20);
    apply(8'h20, 8'h01, 1'b1, 1'b1);
    chk(res == 8'h19 && cout, "R7", res, 8'h19);
    apply(8'h05, 8'h05, 1'b0, 1'b1);
    chk(res == 8'h99 && !cout, "R7", res, 8'h99);
    apply(8'h99, 8'h00, 1'b1, 1'b0);
    chk(res == 8'h00 && cout && zero, "R7", res, 8'h00);

    // R2: new inputs do not reach the outputs before the next rising edge
    @(negedge clk);
    acc = 8'h12; opnd = 8'h34; cin = 1'b0; sub = 1'b0;
    #1;
    chk(res == 8'h00, "R2", res, 8'h00);
    @(negedge clk);
    chk(res == 8'h46, "R2", res, 8'h46);

    // Exhaustive sweep over all decimal byte pairs, both operations and carries
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 100; a++)
          for (int m = 0; m < 100; m++) begin
            apply(to_bcd(a), to_bcd(m), c[0], s[0]);
            check_vec(a, m, c, s);
          end

    // R1: reset after activity clears everything again
    @(negedge clk);
    acc = 8'h99; opnd = 8'h99; cin = 1'b1; sub = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(res == 8'h00 && !cout && !neg && !zero && !ovf, "R1", {res, cout, neg, zero, ovf}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule